// File: doc/BRIEF.md
# APB Watchdog Countdown Timer

This block is a 32-bit down-counting watchdog that sits on an APB slave port. Software sets a reload value, turns the counter on with one enable bit, and must return before the count runs out. When the count expires, a status flag is raised and the counter reloads. Software clears the flag and restarts the count by writing anything to the clear register. The counter advances only on cycles where the single-cycle `tick_en` input is high, so the chip supplies the timebase.

The enable is held by a small control state machine with three states. `ST_IDLE` means the counter is stopped and the interrupt is masked. `ST_RUN` means it is counting and the interrupt may be raised. `ST_LOCKED` means it is counting and control writes are refused. The transitions are:
- **arm**: `ST_IDLE` to `ST_RUN`, on a control write with bit 0 set when `LOCK_MODE` is 0.
- **arm-and-lock**: `ST_IDLE` to `ST_LOCKED`, on the same write when `LOCK_MODE` is 1.
- **disarm**: `ST_RUN` to `ST_IDLE`, on a control write with bit 0 clear.

`ST_LOCKED` is left only by reset. Both arming transitions reload the count from the reload register.

Word map: reload at 0x00, current count at 0x04, control at 0x08 (bit 0 is the enable), clear at 0x0C, status at 0x10 (bit 0 is the pending flag).

Top module: `wdog_apb_timer`

## Requirements
- R1: The APB port never inserts wait states and never reports an error: `pready` is always 1 and `pslverr` is always 0. Read data is valid during the access phase.
- R2: After reset, the reload register (0x00) and the count (0x04) read 0xFFFFFFFF, and control (0x08), status (0x10) and `wdog_irq` read 0.
- R3: While the enable bit is 0, the count does not change, however many ticks arrive.
- R4: A write to the reload register sets both the reload register and the count to the written data in the same access, whether the counter is enabled or not.
- R5: While the enable bit is 1, each cycle with `tick_en` high and no register write lowers the count by one.
- R6: A control write that moves the enable bit from 0 to 1 loads the count from the reload register. A control write that clears the enable bit freezes the count at its present value.
- R7: When a tick brings the count to 0, status bit 0 becomes 1. The next tick loads the count from the reload register, and the status stays 1.
- R8: A write of any data to the clear register (0x0C) sets status to 0 and loads the count from the reload register in the same access.
- R9: `wdog_irq` is high exactly when status bit 0 is 1 and the enable bit is 1.
- R10: When a register write and a tick fall in the same cycle, the write is applied and the tick is dropped.
- R11: Unmapped or misaligned addresses read 0 and ignore writes. The clear register reads 0. The status register cannot be written.
- R12: With `LOCK_MODE` = 1, once the enable bit is 1, control writes are ignored. The counter keeps running and control reads 0x1 until reset restores the defaults of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | One-cycle count pulse |
| wdog_irq | output | 1 | Watchdog interrupt |

## Verification
The assertions assume APB transfers that are well formed:
- the access phase follows a setup phase;
- address and data stay steady while a transfer is in progress;
- `tick_en` is the only thing that advances the count.

The stimulus drives every transfer as a two-cycle setup/access pair and raises `tick_en` only in contiguous bursts. It overlaps a tick with a write on purpose, to test R10. Expected count values are computed in the bench from the number of tick edges each task consumes, including the one taken during a write's setup cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_LOCKED = 2'd2
    } wdog_state_e;

    // word index within the register window; the order is the address map
    typedef enum logic [2:0] {
        REG_RELOAD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_STATUS = 3'd4
    } wdog_reg_e;

endpackage

// File: rtl/wdog_apb_if.sv
module wdog_apb_if
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] reload_q,
    input  logic [DATA_W-1:0] count_q,
    input  logic              enabled,
    input  logic              pending,
    output logic [DATA_W-1:0] prdata,
    output logic              wr_any,
    output logic              wr_reload,
    output logic              wr_ctrl,
    output logic              wr_clear
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             access;

    assign word_idx = paddr[ADDR_W-1:2];
    assign aligned  = (paddr[1:0] == 2'b00);
    assign access   = psel & penable;

    assign wr_any    = access & pwrite;
    assign wr_reload = wr_any & aligned & (word_idx == IDX_W'(REG_RELOAD));
    assign wr_ctrl   = wr_any & aligned & (word_idx == IDX_W'(REG_CTRL));
    assign wr_clear  = wr_any & aligned & (word_idx == IDX_W'(REG_CLEAR));

    always_comb begin
        prdata = '0;
        if (psel && !pwrite && aligned) begin
            case (word_idx)
                IDX_W'(REG_RELOAD): prdata = reload_q;
                IDX_W'(REG_COUNT):  prdata = count_q;
                IDX_W'(REG_CTRL):   prdata = DATA_W'(enabled);
                IDX_W'(REG_STATUS): prdata = DATA_W'(pending);
                default:            prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_ctrl_fsm.sv
module wdog_ctrl_fsm
    import wdog_pkg::*;
#(
    parameter bit LOCK_MODE = 1'b0
) (
    input  logic clk,
    input  logic rstn,
    input  logic wr_ctrl,
    input  logic ctrl_bit,
    output logic enabled,
    output logic arm_pulse
);
    wdog_state_e state_q;
    wdog_state_e state_d;

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        arm_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ctrl && ctrl_bit) begin
                    arm_pulse = 1'b1;
                    state_d   = LOCK_MODE ? ST_LOCKED : ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_ctrl && !ctrl_bit) state_d = ST_IDLE;
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign enabled = (state_q != ST_IDLE);

    generate
        if (LOCK_MODE) begin : g_lock
            AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstn)
                enabled |=> enabled); // R12
        end else begin : g_free
            AST_DISARM_STOPS: assert property (@(posedge clk) disable iff (!rstn)
                (wr_ctrl && !ctrl_bit) |=> !enabled); // R6
        end
    endgenerate

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic              tick_en,
    input  logic              enabled,
    input  logic              arm_pulse,
    input  logic              wr_any,
    input  logic              wr_reload,
    input  logic              wr_clear,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] count_q,
    output logic              pending
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            reload_q <= '1;
            count_q  <= '1;
            pending  <= 1'b0;
        end else if (wr_any) begin
            if (wr_reload) begin
                reload_q <= wdata;
                count_q  <= wdata;
            end
            if (arm_pulse) count_q <= reload_q;
            if (wr_clear) begin
                count_q <= reload_q;
                pending <= 1'b0;
            end
        end else if (enabled && tick_en) begin
            if (count_q == '0) begin
                count_q <= reload_q;
                pending <= 1'b1;
            end else begin
                count_q <= count_q - ONE;
                if (count_q == ONE) pending <= 1'b1;
            end
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstn)
        (!enabled && !wr_any) |=> $stable(count_q)); // R3
    AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rstn)
        wr_reload |=> (count_q == $past(wdata))); // R4
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rstn)
        (enabled && tick_en && !wr_any && count_q > ONE) |=> (count_q == $past(count_q) - ONE)); // R5
    AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rstn)
        (enabled && tick_en && !wr_any && count_q == ONE) |=> pending); // R7
    AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rstn)
        (enabled && tick_en && !wr_any && count_q == '0) |=> (pending && count_q == $past(reload_q))); // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rstn)
        wr_clear |=> (!pending && count_q == $past(reload_q))); // R8

endmodule

// File: rtl/wdog_apb_timer.sv
module wdog_apb_timer #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter bit LOCK_MODE = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              wdog_irq
);
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic              enabled;
    logic              pending;
    logic              arm_pulse;
    logic              wr_any;
    logic              wr_reload;
    logic              wr_ctrl;
    logic              wr_clear;

    wdog_apb_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_apb (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .reload_q  (reload_q),
        .count_q   (count_q),
        .enabled   (enabled),
        .pending   (pending),
        .prdata    (prdata),
        .wr_any    (wr_any),
        .wr_reload (wr_reload),
        .wr_ctrl   (wr_ctrl),
        .wr_clear  (wr_clear)
    );

    wdog_ctrl_fsm #(.LOCK_MODE(LOCK_MODE)) u_fsm (
        .clk       (pclk),
        .rstn      (presetn),
        .wr_ctrl   (wr_ctrl),
        .ctrl_bit  (pwdata[0]),
        .enabled   (enabled),
        .arm_pulse (arm_pulse)
    );

    wdog_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (pclk),
        .rstn      (presetn),
        .tick_en   (tick_en),
        .enabled   (enabled),
        .arm_pulse (arm_pulse),
        .wr_any    (wr_any),
        .wr_reload (wr_reload),
        .wr_clear  (wr_clear),
        .wdata     (pwdata),
        .reload_q  (reload_q),
        .count_q   (count_q),
        .pending   (pending)
    );

    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
    assign wdog_irq = pending & enabled;

    AST_WRITE_BEATS_TICK: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_reload && tick_en) |=> (count_q == $past(pwdata))); // R10

endmodule

// File: tb/wdog_apb_timer_tb.sv
module wdog_apb_timer_tb;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel_a = 1'b0;
    logic        psel_b = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tick_en = 1'b0;
    logic [31:0] prdata_a, prdata_b;
    logic        pready_a, pready_b, pslverr_a, pslverr_b;
    logic        irq_a, irq_b;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5ns pclk = ~pclk;

    wdog_apb_timer #(.LOCK_MODE(1'b0)) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel_a), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
        .pready(pready_a), .pslverr(pslverr_a), .tick_en(tick_en), .wdog_irq(irq_a)
    );

    wdog_apb_timer #(.LOCK_MODE(1'b1)) u_dut_lk (
        .pclk(pclk), .presetn(presetn), .psel(psel_b), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
        .pready(pready_b), .pslverr(pslverr_b), .tick_en(tick_en), .wdog_irq(irq_b)
    );

    localparam logic [11:0] A_RELOAD = 12'h000;
    localparam logic [11:0] A_COUNT  = 12'h004;
    localparam logic [11:0] A_CTRL   = 12'h008;
    localparam logic [11:0] A_CLEAR  = 12'h00C;
    localparam logic [11:0] A_STATUS = 12'h010;
    localparam logic [11:0] A_HOLE   = 12'h014;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compares each read data beat against the scoreboard
    always @(negedge pclk) begin
        if ((psel_a || psel_b) && penable && !pwrite) begin
            sb_item_t it;
            logic [31:0] act;
            act = psel_b ? prdata_b : prdata_a;
            if (sb_q.size() == 0) begin
                check("SB unexpected read", 32'd1, 32'd0);
            end else begin
                it = sb_q.pop_front();
                check(it.tag, act, it.exp);
            end
            check("R1 pready", 32'(psel_b ? pready_b : pready_a), 32'd1);
            check("R1 pslverr", 32'(psel_b ? pslverr_b : pslverr_a), 32'd0);
        end
    end

    // driver tasks: all start and end one time unit after a rising edge
    task automatic rd(input bit sel_b, input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        psel_a = !sel_b; psel_b = sel_b; paddr = a; pwrite = 1'b0; penable = 1'b0;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0;
    endtask

    task automatic wr(input bit sel_b, input logic [11:0] a, input logic [31:0] d);
        psel_a = !sel_b; psel_b = sel_b; paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge pclk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        presetn = 1'b0;
        repeat (2) @(posedge pclk);
        #1;
        presetn = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge pclk);
        #1;
        presetn = 1'b1;

        // R2 reset defaults, R11 hole and clear read as zero
        rd(0, A_RELOAD, 32'hFFFF_FFFF, "R2 reload default");
        rd(0, A_COUNT,  32'hFFFF_FFFF, "R2 count default");
        rd(0, A_CTRL,   32'h0, "R2 ctrl default");
        rd(0, A_STATUS, 32'h0, "R2 status default");
        check("R2 irq default", 32'(irq_a), 32'd0);
        rd(0, A_CLEAR,  32'h0, "R11 clear reads zero");
        rd(0, A_HOLE,   32'h0, "R11 hole reads zero");
        rd(0, 12'h002,  32'h0, "R11 misaligned reads zero");

        // R3 disabled counter holds
        ticks(20);
        rd(0, A_COUNT, 32'hFFFF_FFFF, "R3 hold while off");

        // R4 reload write sets count while off
        wr(0, A_RELOAD, 32'd1000);
        rd(0, A_COUNT, 32'd1000, "R4 count follows reload write");
        ticks(5);
        rd(0, A_COUNT, 32'd1000, "R3 hold after reload write");

        // R5 counting
        wr(0, A_CTRL, 32'd1);
        ticks(500);
        rd(0, A_COUNT, 32'd500, "R5 count after 500 ticks");
        rd(0, A_STATUS, 32'd0, "R5 no expiry yet");

        // R6 freeze then re-arm reload
        wr(0, A_CTRL, 32'd0);
        ticks(100);
        rd(0, A_COUNT, 32'd500, "R6 frozen on disarm");
        wr(0, A_CTRL, 32'd1);
        rd(0, A_COUNT, 32'd1000, "R6 reload on arm");

        // R7 expiry and rollover
        ticks(999);
        rd(0, A_COUNT, 32'd1, "R7 one tick before expiry");
        rd(0, A_STATUS, 32'd0, "R7 not yet pending");
        ticks(1);
        rd(0, A_COUNT, 32'd0, "R7 count at zero");
        rd(0, A_STATUS, 32'd1, "R7 pending at zero");
        check("R9 irq on expiry", 32'(irq_a), 32'd1);
        ticks(1);
        rd(0, A_COUNT, 32'd1000, "R7 rollover reload");
        rd(0, A_STATUS, 32'd1, "R7 stays pending");

        // R9 irq masked by enable
        wr(0, A_CTRL, 32'd0);
        check("R9 irq masked when off", 32'(irq_a), 32'd0);
        rd(0, A_STATUS, 32'd1, "R9 status kept while off");
        wr(0, A_CTRL, 32'd1);
        check("R9 irq back when on", 32'(irq_a), 32'd1);

        // R11 status not writable
        wr(0, A_STATUS, 32'd0);
        rd(0, A_STATUS, 32'd1, "R11 status write ignored");

        // R8 clear with arbitrary data
        ticks(10);
        rd(0, A_COUNT, 32'd990, "R5 count before clear");
        wr(0, A_CLEAR, 32'h5A5A_0055);
        rd(0, A_STATUS, 32'd0, "R8 status cleared");
        rd(0, A_COUNT, 32'd1000, "R8 count reloaded");
        check("R8 irq low after clear", 32'(irq_a), 32'd0);

        // R10 write and tick together: setup cycle ticks, access cycle writes
        tick_en = 1'b1;
        wr(0, A_RELOAD, 32'd200);
        rd(0, A_COUNT, 32'd200, "R10 write wins over tick");

        // R11 hole write ignored
        wr(0, A_HOLE, 32'd7);
        wr(0, 12'h001, 32'd9);
        rd(0, A_RELOAD, 32'd200, "R11 hole write no effect reload");
        rd(0, A_COUNT, 32'd200, "R11 hole write no effect count");

        // R4 reload write while running
        wr(0, A_RELOAD, 32'd5000);
        rd(0, A_COUNT, 32'd5000, "R4 reload write while running");
        ticks(4999);
        rd(0, A_COUNT, 32'd1, "R5 long run");
        rd(0, A_STATUS, 32'd0, "R5 long run no expiry");

        // R12 lock variant
        do_reset();
        rd(0, A_CTRL, 32'd0, "R2 ctrl after reset");
        rd(1, A_CTRL, 32'd0, "R12 lock ctrl default");
        wr(1, A_RELOAD, 32'd4000);
        wr(1, A_CTRL, 32'd1);
        ticks(500);
        rd(1, A_COUNT, 32'd3500, "R12 lock counting");
        wr(1, A_CTRL, 32'd0);
        rd(1, A_CTRL, 32'd1, "R12 ctrl stays set");
        ticks(100);
        rd(1, A_COUNT, 32'd3400, "R12 keeps running");
        wr(1, A_CTRL, 32'd1);
        rd(1, A_COUNT, 32'd3400, "R12 no re-arm reload");
        do_reset();
        rd(1, A_CTRL, 32'd0, "R12 reset unlocks");
        rd(1, A_RELOAD, 32'hFFFF_FFFF, "R12 reload default after reset");
        ticks(50);
        rd(1, A_COUNT, 32'hFFFF_FFFF, "R12 stopped after reset");

        repeat (2) @(posedge pclk);
        check("SB drained", 32'(sb_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2ms;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule